// File: doc/BRIEF.md
# Temperature-Indexed Setting Selector

This block produces an 8-bit setting for each of two output channels. In automatic mode the setting comes from an internal table. The table is addressed by a band number derived from the latest valid signed temperature sample. Each band covers two degrees, and the bands span -40 to +102 degrees, which gives 72 bands. Each table word carries one value per channel. In manual mode both channels take their values straight from two manual setting inputs. These inputs stand for the channel 0 setting register at address 82h and the channel 1 setting register at address 83h.

A disable input overrides everything. While it is high, both channel enables drop and both settings read zero, in either mode. On the board this pin is pulled high, so a pin left unconnected keeps the outputs disabled. The table is a synchronous RAM inside the block. It is loaded through a write port and can be inspected through a registered read port.

Top module: `temp_setting_sel`

## Requirements
- R1: While reset is asserted, both settings read 0. With the disable input low, both enables read 1.
- R2: In automatic mode (auto_mode=1), the settings change one clock after a sample with temp_valid=1 at integer temperature T. They then show the table word at band (T+40)>>1. Channel 0 comes from word bits [7:0] and channel 1 from bits [15:8].
- R3: A sample below -40 selects band 0.
- R4: A sample above +102 selects band 71, and +102 and +103 also fall in band 71.
- R5: Between valid samples, the settings hold, whatever value temp_in carries.
- R6: In manual mode (auto_mode=0), set0 equals man_set0 and set1 equals man_set1 in the same cycle. Table contents and new samples have no effect on the outputs.
- R7: A valid sample taken in manual mode is still recorded. On a switch to automatic mode, the outputs show that sample's band at once, with no new sample needed.
- R8: While off_req=1, en0 and en1 are 0 and set0 and set1 are 0, in both modes. Dropping off_req restores the selected values in the same cycle.
- R9: A table write at tbl_waddr below 72 stores tbl_wdata. tbl_rdata returns the word at tbl_raddr one clock later.
- R10: Writes to tbl_waddr of 72 or more are ignored and leave all stored words unchanged. Reads at such an address return 0.
- R11: Rewriting the table word at the current band shows on the automatic-mode outputs two clocks after the write, without a new sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_in | input | 8 | Signed temperature sample in whole degrees |
| temp_valid | input | 1 | temp_in holds a new sample |
| auto_mode | input | 1 | 1: table-driven settings, 0: manual settings |
| off_req | input | 1 | Disable request, high forces outputs off |
| man_set0 | input | 8 | Manual setting for channel 0 |
| man_set1 | input | 8 | Manual setting for channel 1 |
| tbl_we | input | 1 | Table write strobe |
| tbl_waddr | input | 7 | Table write band address |
| tbl_wdata | input | 16 | Table write word, channel 1 in the upper byte |
| tbl_raddr | input | 7 | Table read band address |
| tbl_rdata | output | 16 | Table read word, one clock after the address |
| set0 | output | 8 | Channel 0 setting |
| set1 | output | 8 | Channel 1 setting |
| en0 | output | 1 | Channel 0 enable |
| en1 | output | 1 | Channel 1 enable |

## Verification
The hardest case to reach from the ports is the return from manual to automatic mode. There the outputs must reflect a sample that arrived while the table values were hidden. The stimulus sends a sample during manual mode and confirms the outputs still follow the manual inputs. It then flips the mode bit with no further sample and checks for the entry of the hidden band. A second hidden case is a table rewrite at the live band. The bench writes a new word at the band already in use and looks for it on the outputs two clocks later. Every table entry is loaded with a distinct value computed from its band, so a band off by one shows as a wrong setting.

// File: rtl/temp_setting_pkg.sv
package temp_setting_pkg;

    localparam int SET_W  = 8;
    localparam int NCH    = 2;
    localparam int TEMP_W = 8;
    localparam int T_LO   = -40;
    localparam int T_HI   = 102;
    localparam int NBANDS = (T_HI - T_LO) / 2 + 1;
    localparam int BAND_W = $clog2(NBANDS);
    localparam int WORD_W = SET_W * NCH;

    typedef logic [BAND_W-1:0] band_t;
    typedef logic [SET_W-1:0]  setting_t;

    typedef struct packed {
        setting_t ch1;
        setting_t ch0;
    } set_pair_t;

    typedef enum logic {
        MODE_MANUAL = 1'b0,
        MODE_AUTO   = 1'b1
    } mode_e;

    function automatic band_t band_of(input logic signed [TEMP_W-1:0] t);
        int v;
        v = int'(t) - T_LO;
        if (v < 0) begin
            return '0;
        end
        v = v >>> 1;
        if (v > NBANDS - 1) begin
            return band_t'(NBANDS - 1);
        end
        return band_t'(v);
    endfunction

endpackage

// File: rtl/temp_band_reg.sv
module temp_band_reg
    import temp_setting_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [TEMP_W-1:0] temp_in,
    input  logic                     temp_valid,
    output band_t                    band_now,
    output band_t                    band_q
);

    assign band_now = band_of(temp_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            band_q <= '0;
        end else if (temp_valid) begin
            band_q <= band_now;
        end
    end

    a_r3_low_clamp: assert property (@(posedge clk) disable iff (rst)
        (temp_valid && (int'(temp_in) < T_LO)) |=> (band_q == '0));

    a_r4_high_clamp: assert property (@(posedge clk) disable iff (rst)
        (temp_valid && (int'(temp_in) > T_HI)) |=> (band_q == band_t'(NBANDS - 1)));

    a_r5_hold_between: assert property (@(posedge clk) disable iff (rst)
        !temp_valid |=> $stable(band_q));

    a_r4_band_in_range: assert property (@(posedge clk) disable iff (rst)
        (int'(band_q) < NBANDS));

endmodule

// File: rtl/setting_table.sv
module setting_table
    import temp_setting_pkg::*;
#(
    parameter int DEPTH = NBANDS,
    parameter int AW    = BAND_W,
    parameter int W     = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] look_addr,
    output logic [W-1:0]  look_q,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_q
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < DEPTH)) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            look_q <= '0;
            rd_q   <= '0;
        end else begin
            look_q <= (int'(look_addr) < DEPTH) ? mem[look_addr] : '0;
            rd_q   <= (int'(rd_addr) < DEPTH) ? mem[rd_addr] : '0;
        end
    end

    a_r10_oob_read_zero: assert property (@(posedge clk) disable iff (rst)
        (int'(rd_addr) >= DEPTH) |=> (rd_q == '0));

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (look_q == '0 && rd_q == '0));

endmodule

// File: rtl/setting_out_stage.sv
module setting_out_stage
    import temp_setting_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  mode_e     mode,
    input  logic      off_req,
    input  set_pair_t tbl_vals,
    input  set_pair_t man_vals,
    output setting_t  set_o [NCH],
    output logic      en_o  [NCH]
);

    setting_t tbl_arr [NCH];
    setting_t man_arr [NCH];

    assign tbl_arr[0] = tbl_vals.ch0;
    assign tbl_arr[1] = tbl_vals.ch1;
    assign man_arr[0] = man_vals.ch0;
    assign man_arr[1] = man_vals.ch1;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        setting_t picked;
        assign picked   = (mode == MODE_AUTO) ? tbl_arr[c] : man_arr[c];
        assign set_o[c] = off_req ? '0 : picked;
        assign en_o[c]  = ~off_req;

        a_r8_off_zero: assert property (@(posedge clk) disable iff (rst)
            (!en_o[c]) |-> (set_o[c] == '0));

        a_r6_manual_follow: assert property (@(posedge clk) disable iff (rst)
            (mode == MODE_MANUAL && en_o[c]) |-> (set_o[c] == man_arr[c]));
    end

endmodule

// File: rtl/temp_setting_sel.sv
module temp_setting_sel
    import temp_setting_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [TEMP_W-1:0] temp_in,
    input  logic                     temp_valid,
    input  logic                     auto_mode,
    input  logic                     off_req,
    input  logic [SET_W-1:0]         man_set0,
    input  logic [SET_W-1:0]         man_set1,
    input  logic                     tbl_we,
    input  logic [BAND_W-1:0]        tbl_waddr,
    input  logic [WORD_W-1:0]        tbl_wdata,
    input  logic [BAND_W-1:0]        tbl_raddr,
    output logic [WORD_W-1:0]        tbl_rdata,
    output logic [SET_W-1:0]         set0,
    output logic [SET_W-1:0]         set1,
    output logic                     en0,
    output logic                     en1
);

    band_t       band_now;
    band_t       band_q;
    band_t       look_addr;
    logic [WORD_W-1:0] look_q;
    set_pair_t   tbl_vals;
    set_pair_t   man_vals;
    mode_e       mode;
    setting_t    set_arr [NCH];
    logic        en_arr  [NCH];

    temp_band_reg u_band (
        .clk        (clk),
        .rst        (rst),
        .temp_in    (temp_in),
        .temp_valid (temp_valid),
        .band_now   (band_now),
        .band_q     (band_q)
    );

    assign look_addr = temp_valid ? band_now : band_q;

    setting_table u_table (
        .clk       (clk),
        .rst       (rst),
        .we        (tbl_we),
        .waddr     (tbl_waddr),
        .wdata     (tbl_wdata),
        .look_addr (look_addr),
        .look_q    (look_q),
        .rd_addr   (tbl_raddr),
        .rd_q      (tbl_rdata)
    );

    assign tbl_vals = set_pair_t'(look_q);
    assign man_vals = '{ch1: man_set1, ch0: man_set0};
    assign mode     = mode_e'(auto_mode);

    setting_out_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .off_req  (off_req),
        .tbl_vals (tbl_vals),
        .man_vals (man_vals),
        .set_o    (set_arr),
        .en_o     (en_arr)
    );

    assign set0 = set_arr[0];
    assign set1 = set_arr[1];
    assign en0  = en_arr[0];
    assign en1  = en_arr[1];

    a_r8_both_disabled: assert property (@(posedge clk) disable iff (rst)
        off_req |-> (!en0 && !en1 && set0 == '0 && set1 == '0));

    a_r5_auto_hold: assert property (@(posedge clk) disable iff (rst)
        (auto_mode && !off_req && !temp_valid && !tbl_we && $past(!temp_valid && !tbl_we))
        |=> (!auto_mode || off_req || $stable(set0)));

endmodule

// File: tb/temp_setting_sel_test.sv
module temp_setting_sel_test;

    logic              clk = 1'b0;
    logic              rst;
    logic signed [7:0] temp_in;
    logic              temp_valid;
    logic              auto_mode;
    logic              off_req;
    logic [7:0]        man_set0;
    logic [7:0]        man_set1;
    logic              tbl_we;
    logic [6:0]        tbl_waddr;
    logic [15:0]       tbl_wdata;
    logic [6:0]        tbl_raddr;
    logic [15:0]       tbl_rdata;
    logic [7:0]        set0;
    logic [7:0]        set1;
    logic              en0;
    logic              en1;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    temp_setting_sel uut (
        .clk(clk), .rst(rst), .temp_in(temp_in), .temp_valid(temp_valid),
        .auto_mode(auto_mode), .off_req(off_req), .man_set0(man_set0),
        .man_set1(man_set1), .tbl_we(tbl_we), .tbl_waddr(tbl_waddr),
        .tbl_wdata(tbl_wdata), .tbl_raddr(tbl_raddr), .tbl_rdata(tbl_rdata),
        .set0(set0), .set1(set1), .en0(en0), .en1(en1)
    );

    function automatic logic [7:0] e0(input int b);
        return 8'(b) ^ 8'h5A;
    endfunction
    function automatic logic [7:0] e1(input int b);
        return 8'hC0 - 8'(b);
    endfunction
    function automatic int band_exp(input int t);
        int v;
        v = t + 40;
        if (v < 0) return 0;
        v = v / 2;
        if (v > 71) return 71;
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic sample(input int t);
        temp_in    = 8'(t);
        temp_valid = 1'b1;
        tick();
        temp_valid = 1'b0;
    endtask

    task automatic tbl_write(input int a, input logic [15:0] d);
        tbl_waddr = 7'(a);
        tbl_wdata = d;
        tbl_we    = 1'b1;
        tick();
        tbl_we    = 1'b0;
    endtask

    task automatic check_band(input string tag, input int t);
        sample(t);
        chk({tag, " ch0"}, 32'(set0), 32'(e0(band_exp(t))));
        chk({tag, " ch1"}, 32'(set1), 32'(e1(band_exp(t))));
    endtask

    task automatic t_reset();
        rst = 1'b1; temp_in = '0; temp_valid = 0; auto_mode = 1; off_req = 0;
        man_set0 = 8'h11; man_set1 = 8'h22; tbl_we = 0; tbl_waddr = '0;
        tbl_wdata = '0; tbl_raddr = '0;
        tick(); tick();
        chk("R1 set0 in reset", 32'(set0), 0);
        chk("R1 set1 in reset", 32'(set1), 0);
        chk("R1 en in reset", {30'd0, en1, en0}, 3);
        rst = 1'b0;
    endtask

    task automatic t_load();
        for (int b = 0; b < 72; b++) tbl_write(b, {e1(b), e0(b)});
    endtask

    task automatic t_auto();
        check_band("R2 T=0", 0);
        check_band("R2 T=25", 25);
        check_band("R2 T=-40", -40);
        check_band("R2 T=-39", -39);
        check_band("R2 T=-38", -38);
        check_band("R2 T=101", 101);
    endtask

    task automatic t_clamp();
        check_band("R3 T=-41", -41);
        check_band("R3 T=-128", -128);
        check_band("R4 T=102", 102);
        check_band("R4 T=103", 103);
        check_band("R4 T=127", 127);
    endtask

    task automatic t_hold();
        sample(25);
        temp_in = 8'sd90;
        tick(); tick(); tick();
        chk("R5 hold ch0", 32'(set0), 32'(e0(32)));
        chk("R5 hold ch1", 32'(set1), 32'(e1(32)));
    endtask

    task automatic t_manual_switch();
        auto_mode = 0; man_set0 = 8'h3C; man_set1 = 8'hE1;
        #1;
        chk("R6 manual ch0", 32'(set0), 32'h3C);
        chk("R6 manual ch1", 32'(set1), 32'hE1);
        sample(100);
        tick();
        chk("R6 manual ignores sample ch0", 32'(set0), 32'h3C);
        chk("R6 manual ignores sample ch1", 32'(set1), 32'hE1);
        man_set0 = 8'h00; man_set1 = 8'hFF;
        #1;
        chk("R6 manual follows ch0", 32'(set0), 32'h00);
        chk("R6 manual follows ch1", 32'(set1), 32'hFF);
        auto_mode = 1;
        #1;
        chk("R7 switch ch0", 32'(set0), 32'(e0(70)));
        chk("R7 switch ch1", 32'(set1), 32'(e1(70)));
        tick();
    endtask

    task automatic t_disable();
        off_req = 1;
        #1;
        chk("R8 off auto sets", {16'd0, set1, set0}, 0);
        chk("R8 off auto en", {30'd0, en1, en0}, 0);
        auto_mode = 0;
        #1;
        chk("R8 off manual sets", {16'd0, set1, set0}, 0);
        chk("R8 off manual en", {30'd0, en1, en0}, 0);
        off_req = 0;
        #1;
        chk("R8 release manual", {16'd0, set1, set0}, {16'd0, man_set1, man_set0});
        chk("R8 release en", {30'd0, en1, en0}, 3);
        auto_mode = 1;
        tick();
    endtask

    task automatic t_ports();
        tbl_raddr = 7'd10;
        tick();
        chk("R9 read 10", 32'(tbl_rdata), {16'd0, e1(10), e0(10)});
        tbl_write(100, 16'hDEAD);
        tbl_write(72, 16'hBEEF);
        tbl_raddr = 7'd100;
        tick();
        chk("R10 oob read", 32'(tbl_rdata), 0);
        tbl_raddr = 7'd36;
        tick();
        chk("R10 entry 36 intact", 32'(tbl_rdata), {16'd0, e1(36), e0(36)});
        tbl_raddr = 7'd8;
        tick();
        chk("R10 entry 8 intact", 32'(tbl_rdata), {16'd0, e1(8), e0(8)});
        tbl_raddr = 7'd71;
        tick();
        chk("R9 read 71", 32'(tbl_rdata), {16'd0, e1(71), e0(71)});
    endtask

    task automatic t_live();
        sample(50);
        chk("R11 before ch0", 32'(set0), 32'(e0(45)));
        tbl_write(45, 16'hA55A);
        tick();
        chk("R11 live ch0", 32'(set0), 32'h5A);
        chk("R11 live ch1", 32'(set1), 32'hA5);
    endtask

    initial begin
        t_reset();
        t_load();
        t_auto();
        t_clamp();
        t_hold();
        t_manual_switch();
        t_disable();
        t_ports();
        t_live();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired got=hung exp=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule